// File: doc/BRIEF.md
# Strided Tile Address Walker

The walker turns a tensor tile description into a stream of linear addresses. A tile is described by up to four dimensions. Each dimension has an extent of 1 to 16 and an unsigned 12-bit stride. The address of an element is a base address plus, for each dimension, the element's index in that dimension times that dimension's stride. The sum wraps modulo 2^16. Because every stride is free, the same walker produces several orders with no data movement. A row-major walk uses shape (4,4) with strides (4,1). Swapping the strides gives a transposed walk. A 4-D walk such as shape (4,2,2,4) with strides (16,4,8,1) keeps each 2x4 tile of an 8x8 matrix contiguous.

A one-cycle start pulse captures the shape, the strides and the base. The block then spends one preparation cycle computing per-dimension step increments. After that it offers one address per cycle on a valid/ready handshake, together with the index vector of the element. A last flag marks the final element. The block has three states. IDLE waits for start and goes to PREP. PREP loads the step table, clears the counters and goes to STREAM. STREAM offers elements and returns to IDLE when the final element is accepted.

Top module: `tile_addr_walker`

## Requirements
- R1: For every offered element, `addr_o` equals `base_i + idx0*s0 + idx1*s1 + idx2*s2 + idx3*s3` modulo 2^16. Here `s<d>` is `stride_i[12d+11:12d]`, and the base and strides are the values captured at start.
- R2: Indices are offered in lexicographic order with dimension 0 (bits [3:0] of `idx_o`) varying fastest. Dimension d appears on `idx_o[4d+3:4d]`. Each index wraps to 0 at its extent and carries into the next outer dimension.
- R3: The field `ext_m1_i[4d+3:4d]` holds the extent of dimension d minus one, so extents run from 1 to 16. With `ready_i` held high, a walk takes exactly one valid cycle per element, which is the product of the extents. A dimension of extent 1 adds no cycles.
- R4: While `valid_o` is high and `ready_i` is low, `valid_o`, `addr_o`, `idx_o` and `last_o` hold their values into the next cycle.
- R5: `last_o` is high only together with the final element, and in every walk it is high on that element. In the cycle after that element is accepted, `valid_o` is low.
- R6: If `start_i` is sampled high in IDLE, `valid_o` is low in the following cycle and high in the one after. The first element is at index zero and base address. Changes on `ext_m1_i`, `stride_i` or `base_i` after the start cycle do not alter the walk.
- R7: A `start_i` pulse during a walk is ignored: the element stream continues unchanged.
- R8: After reset, `valid_o` and `last_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; captures the configuration in IDLE |
| ext_m1_i | input | 16 | Four 4-bit fields, each an extent minus one; dimension 0 in the low bits |
| stride_i | input | 48 | Four 12-bit unsigned strides; dimension 0 in the low bits |
| base_i | input | 16 | Base address added to every element |
| ready_i | input | 1 | Consumer accepts the offered element |
| valid_o | output | 1 | An element is offered |
| addr_o | output | 16 | Linear address of the offered element |
| idx_o | output | 16 | Index vector of the offered element, four 4-bit fields |
| last_o | output | 1 | Offered element is the final one of the walk |

## Verification
The address is kept by an accumulator, not recomputed each cycle. A wrong step-table entry or a misrouted carry therefore corrupts the address on the first accepted beat that crosses the affected dimension, and every later address stays wrong. A counter error shows on `idx_o` in the beat right after it happens. A fault in terminal detection shows as a misplaced `last_o` or as a beat count that differs from the product of the extents. The scoreboard compares every accepted beat against a model built from nested loops, so the first divergence is reported on the exact beat where it occurs.

// File: rtl/tw_pkg.sv
package tw_pkg;
    localparam int TW_NDIM   = 4;
    localparam int TW_IDX_W  = 4;
    localparam int TW_STR_W  = 12;
    localparam int TW_ADDR_W = 16;

    typedef enum logic [1:0] {
        WS_IDLE,
        WS_PREP,
        WS_STREAM
    } walk_state_e;
endpackage

// File: rtl/tw_index_chain.sv
module tw_index_chain #(
    parameter int NDIM  = 4,
    parameter int IDX_W = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear,
    input  logic                       step,
    input  logic [NDIM-1:0][IDX_W-1:0] ext_m1,
    output logic [NDIM-1:0][IDX_W-1:0] idx,
    output logic [NDIM-1:0]            sel,
    output logic                       all_max
);
    logic [NDIM:0]   inner_full;
    logic [NDIM-1:0] at_max;

    assign inner_full[0] = 1'b1;

    for (genvar d = 0; d < NDIM; d++) begin : g_dim
        logic [IDX_W-1:0] cnt_q;

        assign at_max[d]       = (cnt_q == ext_m1[d]);
        assign inner_full[d+1] = inner_full[d] & at_max[d];
        assign sel[d]          = inner_full[d] & ~at_max[d];
        assign idx[d]          = cnt_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt_q <= '0;
            end else if (clear) begin
                cnt_q <= '0;
            end else if (step && inner_full[d]) begin
                cnt_q <= at_max[d] ? '0 : cnt_q + 1'b1;
            end
        end
    end

    assign all_max = inner_full[NDIM];

    // R2: a step that is not the terminal one must move the index vector
    p_step_advances_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear && !all_max) |=> (idx != $past(idx)));

    // R2: a clear always returns every counter to zero
    p_clear_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (idx == '0));
endmodule

// File: rtl/tw_jump_table.sv
module tw_jump_table #(
    parameter int NDIM   = 4,
    parameter int IDX_W  = 4,
    parameter int STR_W  = 12,
    parameter int ADDR_W = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load,
    input  logic [NDIM-1:0][IDX_W-1:0]  ext_m1,
    input  logic [NDIM-1:0][STR_W-1:0]  stride,
    output logic [NDIM-1:0][ADDR_W-1:0] jump
);
    logic [NDIM:0][ADDR_W-1:0]   rewind;
    logic [NDIM-1:0][ADDR_W-1:0] span;
    logic [NDIM-1:0][ADDR_W-1:0] jump_d;

    assign rewind[0] = '0;

    for (genvar d = 0; d < NDIM; d++) begin : g_span
        assign span[d]       = ADDR_W'(ext_m1[d]) * ADDR_W'(stride[d]);
        assign rewind[d+1]   = rewind[d] + span[d];
        assign jump_d[d]     = ADDR_W'(stride[d]) - rewind[d];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            jump <= '0;
        end else if (load) begin
            jump <= jump_d;
        end
    end

    // R1: the innermost step is the plain innermost stride
    p_inner_jump_r1: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (jump[0] == ADDR_W'($past(stride[0]))));
endmodule

// File: rtl/tw_addr_acc.sv
module tw_addr_acc #(
    parameter int NDIM   = 4,
    parameter int ADDR_W = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        init,
    input  logic [ADDR_W-1:0]           base,
    input  logic                        step,
    input  logic [NDIM-1:0]             sel,
    input  logic [NDIM-1:0][ADDR_W-1:0] jump,
    output logic [ADDR_W-1:0]           addr
);
    logic [ADDR_W-1:0] addend;

    always_comb begin
        addend = '0;
        for (int d = 0; d < NDIM; d++) begin
            if (sel[d]) begin
                addend = addend | jump[d];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (init) begin
            addr <= base;
        end else if (step) begin
            addr <= addr + addend;
        end
    end

    // R6: initialisation places the walk at the captured base
    p_init_base_r6: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> (addr == $past(base)));

    // R2: at most one dimension receives the carry on any beat
    p_single_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> $onehot0(sel));
endmodule

// File: rtl/tile_addr_walker.sv
module tile_addr_walker
    import tw_pkg::*;
#(
    parameter int NDIM   = TW_NDIM,
    parameter int IDX_W  = TW_IDX_W,
    parameter int STR_W  = TW_STR_W,
    parameter int ADDR_W = TW_ADDR_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [NDIM*IDX_W-1:0]   ext_m1_i,
    input  logic [NDIM*STR_W-1:0]   stride_i,
    input  logic [ADDR_W-1:0]       base_i,
    input  logic                    ready_i,
    output logic                    valid_o,
    output logic [ADDR_W-1:0]       addr_o,
    output logic [NDIM*IDX_W-1:0]   idx_o,
    output logic                    last_o
);
    walk_state_e state_q, state_d;

    logic [NDIM-1:0][IDX_W-1:0]  ext_q;
    logic [NDIM-1:0][STR_W-1:0]  stride_q;
    logic [ADDR_W-1:0]           base_q;

    logic                        cfg_latch;
    logic                        prep;
    logic                        offer;
    logic                        fire;
    logic                        at_last;
    logic [NDIM-1:0]             carry_sel;
    logic [NDIM-1:0][IDX_W-1:0]  idx_vec;
    logic [NDIM-1:0][ADDR_W-1:0] jump;
    logic [ADDR_W-1:0]           addr_acc;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WS_IDLE:   if (start_i) state_d = WS_PREP;
            WS_PREP:   state_d = WS_STREAM;
            WS_STREAM: if (ready_i && at_last) state_d = WS_IDLE;
            default:   state_d = WS_IDLE;
        endcase
    end

    // State outputs
    always_comb begin
        cfg_latch = 1'b0;
        prep      = 1'b0;
        offer     = 1'b0;
        unique case (state_q)
            WS_IDLE:   cfg_latch = start_i;
            WS_PREP:   prep      = 1'b1;
            WS_STREAM: offer     = 1'b1;
            default:   offer     = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_q    <= '0;
            stride_q <= '0;
            base_q   <= '0;
        end else if (cfg_latch) begin
            ext_q    <= ext_m1_i;
            stride_q <= stride_i;
            base_q   <= base_i;
        end
    end

    assign fire = offer & ready_i;

    tw_index_chain #(
        .NDIM  (NDIM),
        .IDX_W (IDX_W)
    ) i_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (prep),
        .step    (fire),
        .ext_m1  (ext_q),
        .idx     (idx_vec),
        .sel     (carry_sel),
        .all_max (at_last)
    );

    tw_jump_table #(
        .NDIM   (NDIM),
        .IDX_W  (IDX_W),
        .STR_W  (STR_W),
        .ADDR_W (ADDR_W)
    ) i_jumps (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (prep),
        .ext_m1 (ext_q),
        .stride (stride_q),
        .jump   (jump)
    );

    tw_addr_acc #(
        .NDIM   (NDIM),
        .ADDR_W (ADDR_W)
    ) i_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .init  (prep),
        .base  (base_q),
        .step  (fire),
        .sel   (carry_sel),
        .jump  (jump),
        .addr  (addr_acc)
    );

    assign valid_o = offer;
    assign addr_o  = addr_acc;
    assign idx_o   = idx_vec;
    assign last_o  = offer & at_last;

    // R4: a stalled offer holds every output
    p_hold_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> (valid_o && $stable(addr_o) && $stable(idx_o) && $stable(last_o)));

    // R5: an accepted final element ends the offer
    p_drop_after_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && ready_i && last_o) |=> !valid_o);

    // R6: start in IDLE gives one quiet cycle, then the first offer
    p_start_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WS_IDLE && start_i) |=> (!valid_o ##1 valid_o));

    // R1: first offered element sits at base and index zero
    p_first_at_base_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> (addr_o == base_q && idx_o == '0));

    for (genvar d = 0; d < NDIM; d++) begin : g_range
        // R2: no index ever exceeds its dimension's last value
        p_idx_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
            valid_o |-> (idx_vec[d] <= ext_q[d]));
    end
endmodule

// File: tb/test_tile_addr_walker.sv
module test_tile_addr_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] ext_m1_i = '0;
    logic [47:0] stride_i = '0;
    logic [15:0] base_i = '0;
    logic        ready_i = 1'b1;
    logic        valid_o;
    logic [15:0] addr_o;
    logic [15:0] idx_o;
    logic        last_o;

    typedef struct packed {
        logic [15:0] addr;
        logic [15:0] idx;
        logic        last;
    } beat_t;

    beat_t sb[$];
    int    checks = 0;
    int    errors = 0;
    int    vcnt = 0;
    logic  stall_en = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    always #2.5 clk = ~clk;

    tile_addr_walker i_tile_addr_walker (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .ext_m1_i (ext_m1_i),
        .stride_i (stride_i),
        .base_i   (base_i),
        .ready_i  (ready_i),
        .valid_o  (valid_o),
        .addr_o   (addr_o),
        .idx_o    (idx_o),
        .last_o   (last_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        lfsr    <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        ready_i <= stall_en ? (lfsr[0] | lfsr[3]) : 1'b1;
    end

    always @(negedge clk) if (valid_o) vcnt++;

    // Monitor: pops and compares every accepted beat
    logic        prev_stall = 1'b0;
    logic        prev_fin = 1'b0;
    logic [15:0] prev_addr = '0;
    logic [15:0] prev_idx = '0;
    logic        prev_last = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall) begin
                check(valid_o && addr_o == prev_addr && idx_o == prev_idx && last_o == prev_last,
                      "R4", "stalled beat changed", {addr_o, idx_o}, {prev_addr, prev_idx});
            end
            if (prev_fin) begin
                check(!valid_o, "R5", "valid after final accept", 32'(valid_o), 32'd0);
            end
            prev_fin = 1'b0;
            if (valid_o && ready_i) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R5", "beat beyond walk end", 32'(addr_o), 32'hFFFF_FFFF);
                end else begin
                    beat_t e;
                    e = sb.pop_front();
                    check(addr_o == e.addr, "R1", "address", 32'(addr_o), 32'(e.addr));
                    check(idx_o == e.idx, "R2", "index vector", 32'(idx_o), 32'(e.idx));
                    check(last_o == e.last, "R5", "last flag", 32'(last_o), 32'(e.last));
                    prev_fin = e.last;
                end
            end
            prev_stall = valid_o && !ready_i;
            prev_addr  = addr_o;
            prev_idx   = idx_o;
            prev_last  = last_o;
        end
    end

    task automatic run_walk(input int ext[4], input int str[4], input int base, input bit poke);
        int beats = 0;
        int v0;
        for (int i3 = 0; i3 < ext[3]; i3++)
            for (int i2 = 0; i2 < ext[2]; i2++)
                for (int i1 = 0; i1 < ext[1]; i1++)
                    for (int i0 = 0; i0 < ext[0]; i0++) begin
                        beat_t e;
                        e.addr = 16'(base + i0 * str[0] + i1 * str[1] + i2 * str[2] + i3 * str[3]);
                        e.idx  = {4'(i3), 4'(i2), 4'(i1), 4'(i0)};
                        e.last = (i0 == ext[0] - 1) && (i1 == ext[1] - 1) &&
                                 (i2 == ext[2] - 1) && (i3 == ext[3] - 1);
                        sb.push_back(e);
                        beats++;
                    end
        @(negedge clk);
        for (int d = 0; d < 4; d++) begin
            ext_m1_i[4*d +: 4]  = 4'(ext[d] - 1);
            stride_i[12*d +: 12] = 12'(str[d]);
        end
        base_i  = 16'(base);
        start_i = 1'b1;
        v0 = vcnt;
        @(negedge clk);
        start_i = 1'b0;
        check(!valid_o, "R6", "valid in preparation cycle", 32'(valid_o), 32'd0);
        ext_m1_i = 16'h5A3C;
        stride_i = 48'h123_456_789_ABC;
        base_i   = 16'h7777;
        @(negedge clk);
        check(valid_o, "R6", "valid two cycles after start", 32'(valid_o), 32'd1);
        if (poke) begin
            repeat (3) @(negedge clk);
            start_i  = 1'b1;
            ext_m1_i = 16'h0000;
            base_i   = 16'h4242;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
        check(!valid_o, "R5", "idle after walk", 32'(valid_o), 32'd0);
        if (!stall_en) begin
            check(vcnt - v0 == beats, "R3", "valid cycles per walk", 32'(vcnt - v0), 32'(beats));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!valid_o && !last_o, "R8", "outputs in reset", {valid_o, last_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!valid_o && !last_o, "R8", "outputs after reset", {valid_o, last_o}, 32'd0);

        run_walk('{4, 4, 1, 1}, '{1, 4, 0, 0}, 0, 1'b0);          // R1 row-major
        run_walk('{3, 4, 1, 1}, '{4, 1, 0, 0}, 16'h100, 1'b0);    // R1 transposed
        run_walk('{4, 2, 2, 4}, '{1, 8, 4, 16}, 0, 1'b0);         // R1 tiled 4-D
        run_walk('{3, 1, 1, 5}, '{2, 100, 7, 50}, 16'h20, 1'b0);  // R3 extent-1 skip
        run_walk('{1, 1, 1, 1}, '{9, 9, 9, 9}, 16'hABCD, 1'b0);   // R5 single element
        run_walk('{16, 1, 1, 1}, '{3, 0, 0, 0}, 16'hFFF0, 1'b1);  // R7 start while busy

        stall_en = 1'b1;                                           // R4 stalls
        run_walk('{4, 2, 2, 4}, '{1, 8, 4, 16}, 16'h0400, 1'b1);
        run_walk('{16, 16, 8, 2}, '{12'hFFF, 12'h800, 12'h123, 12'hFFF}, 16'hFF00, 1'b0); // R1 wrap
        stall_en = 1'b0;
        repeat (2) @(negedge clk);
        run_walk('{2, 3, 2, 2}, '{12'h7FF, 1, 12'h400, 12'h010}, 16'h1234, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R5 watchdog: walk did not complete, actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule